// File: doc/BRIEF.md
# Scatter-Gather Sequencer Control Register File

This block is the software-facing register bank for a table-driven scatter-gather sequencer. A processor reaches it over a 32-bit AXI4-Lite slave port. Through it, software programs the base address of a descriptor chain together with the QoS and protection attributes for the data transfers, launches a run, stops a run with a keyed write, and follows the run's progress through live address and status readback.

Toward the sequencer the block drives a one-cycle launch pulse, a one-cycle stop pulse, the table base address, and the QoS and protection values. From the sequencer it receives a busy level, one-cycle done, error and interrupt pulses, and the current table, source and destination addresses. A single level-sensitive interrupt line is asserted while an unmasked interrupt is pending.

The register window holds eight 32-bit words. Word 0 is the control/status word. Word 1 reads as zero. Words 2 and 3 form the 64-bit table address. Words 4 and 5 form the live source address, and words 6 and 7 form the live destination address; each pair has its low half in the even word.

Top module: `sg_ctl_regs`

## Requirements
- R1: After reset, every readable word is zero, `seq_start` and `seq_abort` are low, `irq` is low, and `seq_tbl_base`, `seq_qos` and `seq_prot` are zero.
- R2: When idle, a control-word write with byte lane 0 enabled and bit 0 set raises `seq_start` for exactly one cycle, in the cycle after the write is accepted. A control-word write with lane 2 enabled stores QoS from bits [19:16] and protection from bits [22:20]. These values are driven on `seq_qos` and `seq_prot` and read back in the same positions.
- R3: While busy (`seq_busy` high, or a launch pulse in flight), writes that would launch a run or change QoS, protection or the table address (words 2 and 3) are ignored.
- R4: A control-word write with lane 3 enabled and bits [31:24] equal to 0x6D raises `seq_abort` for one cycle, but only while busy. Any other key value, or any write while idle, leaves `seq_abort` low.
- R5: Control bit 5 (abort status) is set when an abort pulse is issued. It stays set after the run ends and is cleared by the next launch.
- R6: Control bit 4 (error status) is set when `seq_done` and `seq_err` are high together. It stays set until the next launch clears it.
- R7: Control bit 1 (interrupt pending) is set by a `seq_int` pulse and cleared by writing 1 to bit 1 with lane 0 enabled; a pulse in the same cycle wins. Bit 2 is a read/write interrupt enable, and `irq` is high exactly when pending and enable are both set.
- R8: Control bit 3 reads 1 while busy and 0 otherwise.
- R9: While idle, words 2 and 3 read back the programmed table address, with bits [1:0] always zero. While busy, they return `seq_cur_tbl`.
- R10: Words 4 and 5 return `seq_cur_rd`, and words 6 and 7 return `seq_cur_wr`. Word 1, the key field [31:24] and all unassigned control bits read as zero.
- R11: Every write response and read response is OKAY (0). Read data becomes valid in the cycle after the read address is accepted, and it is held, along with the write response, until the master takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 5 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 5 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| seq_start | output | 1 | One-cycle launch pulse |
| seq_abort | output | 1 | One-cycle stop pulse |
| seq_tbl_base | output | ADDR_W | Table base address |
| seq_qos | output | 4 | QoS value for transfers |
| seq_prot | output | 3 | Protection value for transfers |
| seq_busy | input | 1 | Sequencer running |
| seq_done | input | 1 | Run finished pulse |
| seq_err | input | 1 | Run ended on error (with done) |
| seq_int | input | 1 | Interrupt request pulse |
| seq_cur_tbl | input | ADDR_W | Current table entry address |
| seq_cur_rd | input | ADDR_W | Current source address |
| seq_cur_wr | input | ADDR_W | Current destination address |
| irq | output | 1 | Interrupt line |

## Verification
The embedded assertions check the following on every cycle: launch and stop pulses last one cycle and never coincide; QoS, protection and the table address hold steady while busy; a stop pulse always comes with the abort status bit; the sticky error bit falls only on a launch; the pending bit falls only on a write-one-to-clear; and the AXI response channels hold until they are taken. The bench scenarios cover the behaviours that depend on register values seen through reads. These include the exact key value that stops a run, the switch of words 2 and 3 to the live table address during a run, the word map for the progress addresses, the enable-masked interrupt line, and the clearing of sticky status by a new launch.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned WIDE_W  = 64;

  // word offsets inside the 8-word window
  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_RSVD   = 3'd1;
  localparam logic [2:0] OFS_TBL_LO = 3'd2;
  localparam logic [2:0] OFS_TBL_HI = 3'd3;

  // control word bit positions
  localparam int unsigned B_START = 0;
  localparam int unsigned B_PEND  = 1;
  localparam int unsigned B_IEN   = 2;
  localparam int unsigned B_BUSY  = 3;
  localparam int unsigned B_ERR   = 4;
  localparam int unsigned B_ABT   = 5;
  localparam int unsigned QOS_LSB = 16;
  localparam int unsigned PRT_LSB = 20;
  localparam int unsigned KEY_LSB = 24;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/sgc_axil_port.sv
module sgc_axil_port
  import sgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [REG_AW-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [WORD_W-1:0] s_wdata,
  input  logic [3:0]        s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [REG_AW-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [WORD_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              wr_fire,
  output logic [2:0]        wr_word,
  output logic [WORD_W-1:0] wr_data,
  output logic [3:0]        wr_strb,
  output logic [2:0]        rd_word,
  input  logic [WORD_W-1:0] rd_data
);
  logic              bvalid_q, bvalid_n;
  logic              rvalid_q, rvalid_n;
  logic [WORD_W-1:0] rdata_q,  rdata_n;
  logic              rd_fire;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^{s_awaddr[1:0], s_araddr[1:0]};

  // write path: address and data are taken together, one response at a time
  assign wr_fire   = s_awvalid && s_wvalid && !bvalid_q;
  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign wr_word   = s_awaddr[4:2];
  assign wr_data   = s_wdata;
  assign wr_strb   = s_wstrb;

  // read path: one outstanding read, data captured at address acceptance
  assign s_arready = !rvalid_q;
  assign rd_fire   = s_arvalid && !rvalid_q;
  assign rd_word   = s_araddr[4:2];

  always_comb begin
    bvalid_n = bvalid_q;
    if (wr_fire)       bvalid_n = 1'b1;
    else if (s_bready) bvalid_n = 1'b0;

    rvalid_n = rvalid_q;
    rdata_n  = rdata_q;
    if (rd_fire) begin
      rvalid_n = 1'b1;
      rdata_n  = rd_data;
    end else if (s_rready) begin
      rvalid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      bvalid_q <= bvalid_n;
      rvalid_q <= rvalid_n;
      if (rd_fire) rdata_q <= rdata_n;
    end
  end

  assign s_bvalid = bvalid_q;
  assign s_bresp  = RESP_OKAY;
  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_rresp  = RESP_OKAY;

  // R11: a pending write response stays until taken
  p_bresp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  // R11: pending read data stays valid and unchanged until taken
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
endmodule

// File: rtl/sgc_ctrl_core.sv
module sgc_ctrl_core
  import sgc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter logic [7:0]  ABORT_KEY = 8'h6D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [2:0]        wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [3:0]        wr_strb,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              seq_err,
  input  logic              seq_int,
  output logic              start_q,
  output logic              abort_q,
  output logic [ADDR_W-1:0] tbl_q,
  output logic [3:0]        qos_q,
  output logic [2:0]        prot_q,
  output logic              ien_q,
  output logic              pend_q,
  output logic              err_q,
  output logic              abt_q,
  output logic              busy_v
);
  localparam int unsigned LANES = WORD_W / 8;

  logic              ctrl_hit, tbl_hit, go, kill, pend_clr;
  logic [WIDE_W-1:0] tbl_wide;
  logic [ADDR_W-1:0] tbl_n;
  logic [3:0]        qos_n;
  logic [2:0]        prot_n;
  logic              ien_n, pend_n, err_n, abt_n;

  assign busy_v   = seq_busy || start_q;
  assign ctrl_hit = wr_fire && (wr_word == OFS_CTRL);
  assign tbl_hit  = wr_fire && !busy_v &&
                    ((wr_word == OFS_TBL_LO) || (wr_word == OFS_TBL_HI));
  assign go       = ctrl_hit && wr_strb[0] && wr_data[B_START] && !busy_v;
  assign kill     = ctrl_hit && wr_strb[3] && busy_v &&
                    (wr_data[KEY_LSB +: 8] == ABORT_KEY);
  assign pend_clr = ctrl_hit && wr_strb[0] && wr_data[B_PEND];

  always_comb begin
    tbl_wide = WIDE_W'(tbl_q);
    if (tbl_hit) begin
      for (int b = 0; b < LANES; b++) begin
        if (wr_strb[b]) tbl_wide[(wr_word[0] ? WORD_W : 0) + b*8 +: 8] = wr_data[b*8 +: 8];
      end
    end
    tbl_n      = tbl_wide[ADDR_W-1:0];
    tbl_n[1:0] = 2'b00;

    qos_n  = qos_q;
    prot_n = prot_q;
    if (ctrl_hit && wr_strb[2] && !busy_v) begin
      qos_n  = wr_data[QOS_LSB +: 4];
      prot_n = wr_data[PRT_LSB +: 3];
    end

    ien_n = (ctrl_hit && wr_strb[0]) ? wr_data[B_IEN] : ien_q;

    pend_n = pend_q;
    if (seq_int)       pend_n = 1'b1;
    else if (pend_clr) pend_n = 1'b0;

    err_n = err_q;
    if (go)                       err_n = 1'b0;
    else if (seq_done && seq_err) err_n = 1'b1;

    abt_n = abt_q;
    if (go)        abt_n = 1'b0;
    else if (kill) abt_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      tbl_q   <= '0;
      qos_q   <= '0;
      prot_q  <= '0;
      ien_q   <= 1'b0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      start_q <= go;
      abort_q <= kill;
      if (tbl_hit) tbl_q <= tbl_n;
      qos_q   <= qos_n;
      prot_q  <= prot_n;
      ien_q   <= ien_n;
      pend_q  <= pend_n;
      err_q   <= err_n;
      abt_q   <= abt_n;
    end
  end

  // R2: the launch pulse never lasts more than one cycle
  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R4: launch and stop are never requested together
  p_no_start_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && abort_q));
  // R5: a stop pulse is always reflected in the abort status bit
  p_abort_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> abt_q);
  // R6: sticky error only drops on a launch
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> start_q);
  // R7: pending only drops after a write-one-to-clear
  p_pend_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(pend_clr));
  // R3: programmed attributes frozen while busy
  p_frozen_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_v |=> $stable({qos_q, prot_q, tbl_q}));
endmodule

// File: rtl/sgc_rdmux.sv
module sgc_rdmux
  import sgc_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [2:0]        rd_word,
  input  logic              busy_v,
  input  logic [ADDR_W-1:0] tbl_q,
  input  logic [3:0]        qos_q,
  input  logic [2:0]        prot_q,
  input  logic              ien_q,
  input  logic              pend_q,
  input  logic              err_q,
  input  logic              abt_q,
  input  logic [ADDR_W-1:0] cur_tbl,
  input  logic [ADDR_W-1:0] cur_rd,
  input  logic [ADDR_W-1:0] cur_wr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned NPAIR = 3;

  logic [ADDR_W-1:0] src [NPAIR];
  logic [WIDE_W-1:0] ext [NPAIR];
  logic [WORD_W-1:0] ctrl_word;
  logic [1:0]        sel;
  logic [WIDE_W-1:0] pair;

  assign src[0] = busy_v ? cur_tbl : tbl_q;
  assign src[1] = cur_rd;
  assign src[2] = cur_wr;

  for (genvar i = 0; i < NPAIR; i++) begin : g_ext
    assign ext[i] = WIDE_W'(src[i]);
  end

  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[QOS_LSB +: 4]   = qos_q;
    ctrl_word[PRT_LSB +: 3]   = prot_q;
    ctrl_word[B_ABT]          = abt_q;
    ctrl_word[B_ERR]          = err_q;
    ctrl_word[B_BUSY]         = busy_v;
    ctrl_word[B_IEN]          = ien_q;
    ctrl_word[B_PEND]         = pend_q;

    sel  = rd_word[2:1] - 2'd1;
    pair = (sel < 2'd3) ? ext[sel] : '0;

    case (rd_word)
      OFS_CTRL: rd_data = ctrl_word;
      OFS_RSVD: rd_data = '0;
      default:  rd_data = rd_word[0] ? pair[WIDE_W-1:WORD_W] : pair[WORD_W-1:0];
    endcase
  end
endmodule

// File: rtl/sg_ctl_regs.sv
module sg_ctl_regs
  import sgc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter logic [7:0]  ABORT_KEY = 8'h6D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [4:0]        s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [4:0]        s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              seq_start,
  output logic              seq_abort,
  output logic [ADDR_W-1:0] seq_tbl_base,
  output logic [3:0]        seq_qos,
  output logic [2:0]        seq_prot,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              seq_err,
  input  logic              seq_int,
  input  logic [ADDR_W-1:0] seq_cur_tbl,
  input  logic [ADDR_W-1:0] seq_cur_rd,
  input  logic [ADDR_W-1:0] seq_cur_wr,
  output logic              irq
);
  logic [1:0]  rst_sync_q;
  logic        rst_i;
  logic        wr_fire;
  logic [2:0]  wr_word, rd_word;
  logic [31:0] wr_data, rd_data;
  logic [3:0]  wr_strb;
  logic        ien_q, pend_q, err_q, abt_q, busy_v;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  sgc_axil_port u_port (
    .clk       (clk),
    .rst_n     (rst_i),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_awaddr  (s_awaddr),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_wdata   (s_wdata),
    .s_wstrb   (s_wstrb),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_bresp   (s_bresp),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_araddr  (s_araddr),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .wr_fire   (wr_fire),
    .wr_word   (wr_word),
    .wr_data   (wr_data),
    .wr_strb   (wr_strb),
    .rd_word   (rd_word),
    .rd_data   (rd_data)
  );

  sgc_ctrl_core #(.ADDR_W(ADDR_W), .ABORT_KEY(ABORT_KEY)) u_core (
    .clk      (clk),
    .rst_n    (rst_i),
    .wr_fire  (wr_fire),
    .wr_word  (wr_word),
    .wr_data  (wr_data),
    .wr_strb  (wr_strb),
    .seq_busy (seq_busy),
    .seq_done (seq_done),
    .seq_err  (seq_err),
    .seq_int  (seq_int),
    .start_q  (seq_start),
    .abort_q  (seq_abort),
    .tbl_q    (seq_tbl_base),
    .qos_q    (seq_qos),
    .prot_q   (seq_prot),
    .ien_q    (ien_q),
    .pend_q   (pend_q),
    .err_q    (err_q),
    .abt_q    (abt_q),
    .busy_v   (busy_v)
  );

  sgc_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .rd_word (rd_word),
    .busy_v  (busy_v),
    .tbl_q   (seq_tbl_base),
    .qos_q   (seq_qos),
    .prot_q  (seq_prot),
    .ien_q   (ien_q),
    .pend_q  (pend_q),
    .err_q   (err_q),
    .abt_q   (abt_q),
    .cur_tbl (seq_cur_tbl),
    .cur_rd  (seq_cur_rd),
    .cur_wr  (seq_cur_wr),
    .rd_data (rd_data)
  );

  assign irq = pend_q && ien_q;

  // R7: the line never rises without a pending request
  p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(irq) |-> pend_q);
  // R4: a stop request is only issued while a run is active or launching
  p_abort_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_i)
    seq_abort |-> $past(busy_v));
endmodule

// File: tb/tb_sg_ctl_regs.sv
module tb_sg_ctl_regs;
  localparam int unsigned AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [4:0]    s_awaddr = 0, s_araddr = 0;
  logic [31:0]   s_wdata = 0;
  logic [3:0]    s_wstrb = 0;
  logic          s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]    s_bresp, s_rresp;
  logic [31:0]   s_rdata;
  logic          seq_start, seq_abort, irq;
  logic [AW-1:0] seq_tbl_base;
  logic [3:0]    seq_qos;
  logic [2:0]    seq_prot;
  logic          seq_busy = 0, seq_done = 0, seq_err = 0, seq_int = 0;
  logic [AW-1:0] seq_cur_tbl = 0, seq_cur_rd = 0, seq_cur_wr = 0;

  int errors = 0;
  int checks = 0;
  logic cap_start, cap_abort;
  logic [31:0] rd_val;

  always #5 clk = ~clk;

  sg_ctl_regs #(.ADDR_W(AW)) dut (.*);

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic        exp_start;
    logic        exp_abort;
    logic [3:0]  req;
  } vec_t;

  // idle-state programming and readback
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'h08, 32'h12345677, 4'hF, 32'h0,        1'b0, 1'b0, 4'd9},
    '{1'b1, 5'h0C, 32'hDEADBEEF, 4'hF, 32'h0,        1'b0, 1'b0, 4'd9},
    '{1'b0, 5'h08, 32'h0,        4'h0, 32'h12345674, 1'b0, 1'b0, 4'd9},
    '{1'b0, 5'h0C, 32'h0,        4'h0, 32'hDEADBEEF, 1'b0, 1'b0, 4'd9},
    '{1'b1, 5'h00, 32'h00570000, 4'h4, 32'h0,        1'b0, 1'b0, 4'd2},
    '{1'b0, 5'h00, 32'h0,        4'h0, 32'h00570000, 1'b0, 1'b0, 4'd2},
    '{1'b0, 5'h04, 32'h0,        4'h0, 32'h00000000, 1'b0, 1'b0, 4'd10},
    '{1'b1, 5'h00, 32'h00000004, 4'h1, 32'h0,        1'b0, 1'b0, 4'd7},
    '{1'b0, 5'h00, 32'h0,        4'h0, 32'h00570004, 1'b0, 1'b0, 4'd7},
    '{1'b1, 5'h00, 32'h6D000000, 4'h8, 32'h0,        1'b0, 1'b0, 4'd4},
    '{1'b0, 5'h00, 32'h0,        4'h0, 32'h00570004, 1'b0, 1'b0, 4'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic axi_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] st);
    @(negedge clk);
    s_awvalid = 1; s_wvalid = 1; s_awaddr = a; s_wdata = d; s_wstrb = st;
    while (!s_awready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    cap_start = seq_start;
    cap_abort = seq_abort;
    chk(s_bvalid && s_bresp == 2'b00, "R11 bresp", {62'd0, s_bresp}, 64'd0);
  endtask

  task automatic axi_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    s_arvalid = 1; s_araddr = a;
    while (!s_arready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_arvalid = 0;
    chk(s_rvalid && s_rresp == 2'b00, "R11 rvalid/rresp", {62'd0, s_rresp}, 64'd0);
    d = s_rdata;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    axi_read(a, v);
    chk(v == exp, req, {32'd0, v}, {32'd0, exp});
  endtask

  task automatic pulse_int();
    @(negedge clk); seq_int = 1;
    @(negedge clk); seq_int = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(!seq_start && !seq_abort && !irq, "R1 pulses/irq", {61'd0, seq_start, seq_abort, irq}, 64'd0);
    chk(seq_tbl_base == 0 && seq_qos == 0 && seq_prot == 0, "R1 outputs", seq_tbl_base, 64'd0);
    rd_chk(5'h00, 32'h0, "R1 ctrl");
    rd_chk(5'h08, 32'h0, "R1 tbl");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        axi_write(VECS[i].addr, VECS[i].data, VECS[i].strb);
        chk(cap_start == VECS[i].exp_start && cap_abort == VECS[i].exp_abort,
            $sformatf("R%0d pulses vec%0d", VECS[i].req, i),
            {62'd0, cap_start, cap_abort}, {62'd0, VECS[i].exp_start, VECS[i].exp_abort});
      end else begin
        axi_read(VECS[i].addr, rd_val);
        chk(rd_val == VECS[i].exp, $sformatf("R%0d read vec%0d", VECS[i].req, i),
            {32'd0, rd_val}, {32'd0, VECS[i].exp});
      end
    end

    // R2: programmed values on the sequencer side
    chk(seq_tbl_base == 64'hDEADBEEF_12345674, "R2 tbl_base", seq_tbl_base, 64'hDEADBEEF_12345674);
    chk(seq_qos == 4'h7 && seq_prot == 3'h5, "R2 qos/prot", {57'd0, seq_prot, seq_qos}, {57'd0, 3'h5, 4'h7});

    // R2: launch while idle, one-cycle pulse
    axi_write(5'h00, 32'h00000005, 4'h1);
    chk(cap_start == 1'b1 && cap_abort == 1'b0, "R2 start pulse", {62'd0, cap_start, cap_abort}, 64'd2);
    @(negedge clk);
    chk(seq_start == 1'b0, "R2 start one cycle", {63'd0, seq_start}, 64'd0);

    seq_busy = 1;
    seq_cur_tbl = 64'h0000_0001_0000_0100;
    seq_cur_rd  = 64'hAAAA_0000_1111_2222;
    seq_cur_wr  = 64'h5555_6666_7777_8888;
    // R8: busy bit
    rd_chk(5'h00, 32'h0057000C, "R8 busy bit");
    // R9: live table address while busy
    rd_chk(5'h08, 32'h00000100, "R9 live tbl lo");
    rd_chk(5'h0C, 32'h00000001, "R9 live tbl hi");
    // R10: progress words
    rd_chk(5'h10, 32'h11112222, "R10 rd lo");
    rd_chk(5'h14, 32'hAAAA0000, "R10 rd hi");
    rd_chk(5'h18, 32'h77778888, "R10 wr lo");
    rd_chk(5'h1C, 32'h55556666, "R10 wr hi");

    // R3: writes ignored while busy
    axi_write(5'h00, 32'h00110005, 4'h5);
    chk(cap_start == 1'b0, "R3 no start while busy", {63'd0, cap_start}, 64'd0);
    axi_write(5'h08, 32'hFFFFFFF0, 4'hF);
    rd_chk(5'h00, 32'h0057000C, "R3 qos/prot kept");
    chk(seq_tbl_base == 64'hDEADBEEF_12345674, "R3 tbl kept", seq_tbl_base, 64'hDEADBEEF_12345674);

    // R4: wrong key while busy
    axi_write(5'h00, 32'h6C000000, 4'h8);
    chk(cap_abort == 1'b0, "R4 wrong key", {63'd0, cap_abort}, 64'd0);
    rd_chk(5'h00, 32'h0057000C, "R4 no abort status");

    // R7: pending and enable masking
    pulse_int();
    chk(irq == 1'b1, "R7 irq enabled", {63'd0, irq}, 64'd1);
    rd_chk(5'h00, 32'h0057000E, "R7 pending set");
    axi_write(5'h00, 32'h00000006, 4'h1);
    chk(irq == 1'b0, "R7 w1c clears irq", {63'd0, irq}, 64'd0);
    rd_chk(5'h00, 32'h0057000C, "R7 pending cleared");
    axi_write(5'h00, 32'h00000000, 4'h1);
    pulse_int();
    chk(irq == 1'b0, "R7 masked", {63'd0, irq}, 64'd0);
    rd_chk(5'h00, 32'h0057000A, "R7 pending while masked");

    // R4 / R5: correct key while busy
    axi_write(5'h00, 32'h6D000000, 4'h8);
    chk(cap_abort == 1'b1 && cap_start == 1'b0, "R4 key abort", {62'd0, cap_start, cap_abort}, 64'd1);
    rd_chk(5'h00, 32'h0057002A, "R5 aborting status");

    // R6: run ends with error; R5 stays
    @(negedge clk); seq_busy = 0; seq_done = 1; seq_err = 1;
    @(negedge clk); seq_done = 0; seq_err = 0;
    rd_chk(5'h00, 32'h00570032, "R6 error and R5 abort sticky");
    rd_chk(5'h08, 32'h12345674, "R9 idle tbl readback");

    // new launch clears sticky status
    axi_write(5'h00, 32'h00000001, 4'h1);
    chk(cap_start == 1'b1, "R2 relaunch", {63'd0, cap_start}, 64'd1);
    rd_chk(5'h00, 32'h00570002, "R5 R6 cleared by start");

    // R1: reset during operation
    do_reset();
    rd_chk(5'h00, 32'h0, "R1 ctrl after reset");
    rd_chk(5'h0C, 32'h0, "R1 tbl after reset");
    chk(!irq && seq_qos == 0 && seq_tbl_base == 0, "R1 outputs after reset", seq_tbl_base, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule